// File: doc/BRIEF.md
# GPIO Event Detector with Per-Bank Interrupts

This block watches a set of general-purpose input pins and records interesting activity on each one in a sticky status bit. Per pin, software can arm any mix of six trigger conditions. Four are evaluated on the already synchronized level: a rising edge, a falling edge, a high level and a low level. Two are edges taken from a raw copy of the pin after a single capture flop, a rising one and a falling one. Any armed condition that holds sets the pin's status bit. The bit stays set until software writes a 1 to it.

Pins are grouped into 32-bit lanes called banks. Each bank drives one interrupt output, which is high while any status bit of that bank is set. Edge captures stay cleared after software acknowledges them. A level capture comes straight back while its level persists. Arming both edge enables of a pin traps transitions in both directions.

Access is through a simple 32-bit register port: a one-cycle write strobe with address and data, and a combinational read of the addressed word.

Top module: `gpio_evt_top`

## Requirements
- R1: After reset every enable register and every status bit is 0, and both interrupt outputs are low.
- R2: With the rising enable set (word 0x4C plus 4 per bank, bit = pin mod 32), a 0-to-1 change of the synchronized level sets the pin's status bit at the first clock edge that sees the new level. A 1-to-0 change does not set it.
- R3: The falling enable (0x58 plus 4 per bank) captures 1-to-0 changes. With both the rising and the falling enable set, each of the two directions sets the bit.
- R4: The high enable (0x64 plus 4 per bank) sets the status bit on every clock edge at which the synchronized level is 1.
- R5: The low enable (0x70 plus 4 per bank) sets the status bit while the level is 0. Clearing a level capture while its level persists leaves the bit set. Once the level has gone, the clear holds.
- R6: The raw-path rising enable (0x7C plus 4 per bank) and the raw-path falling enable (0x88 plus 4 per bank) capture transitions of the raw pin input. Each capture appears one clock edge later than a synchronized capture of the same change would.
- R7: Writing to the status word (0x40 plus 4 per bank) clears each bit that is written as 1 and leaves each bit written as 0 alone. An edge capture that has been cleared stays clear until a new edge occurs.
- R8: When a new capture and a clearing write hit the same bit at the same clock edge, the bit ends up set.
- R9: Interrupt output b is the OR of bank b's status bits. A capture in one bank does not raise the other bank's output.
- R10: Enable words read back as written. Bits for pin numbers at or above the pin count read 0. Addresses outside the fourteen words read 0.
- R11: A pin whose six enables are all 0 never sets its status bit, whatever its inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_level | input | 54 | Synchronized pin levels |
| pin_raw | input | 54 | Raw pin inputs for the raw-path edge detectors |
| irq_bank | output | 2 | One interrupt per bank, high while any status bit of the bank is set |

## Verification
A synchronized capture sets its status bit, and the bank interrupt with it, at the first rising edge that samples the changed level. A raw-path capture lands one edge later, because of the extra capture flop. A register write takes effect at the edge that samples the strobe, and reads are combinational. The bench therefore changes inputs on the falling edge and reads results after the following falling edge, or after the second one for raw-path captures. For raw-path captures it also checks the intermediate falling edge, which must show no capture yet. In the set-wins case the bench drives the new edge and the clearing write in the same half cycle, so both reach the same rising edge.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int LANE_W    = 32;
    localparam int NUM_KINDS = 7;

    // Register word kinds; kind 0 is the sticky status, the rest are enables.
    typedef enum logic [2:0] {
        K_STAT  = 3'd0,
        K_RISE  = 3'd1,
        K_FALL  = 3'd2,
        K_HIGH  = 3'd3,
        K_LOW   = 3'd4,
        K_ARISE = 3'd5,
        K_AFALL = 3'd6
    } evt_kind_e;

    function automatic logic [7:0] kind_base(evt_kind_e k);
        logic [7:0] base;
        unique case (k)
            K_STAT:  base = 8'h40;
            K_RISE:  base = 8'h4C;
            K_FALL:  base = 8'h58;
            K_HIGH:  base = 8'h64;
            K_LOW:   base = 8'h70;
            K_ARISE: base = 8'h7C;
            K_AFALL: base = 8'h88;
            default: base = 8'h00;
        endcase
        return base;
    endfunction

    function automatic logic [7:0] reg_addr(evt_kind_e k, int bank);
        return kind_base(k) + 8'(4 * bank);
    endfunction

    // Bits of a bank's word that map to existing pins.
    function automatic logic [LANE_W-1:0] lane_mask(int npins, int bank);
        logic [LANE_W-1:0] m;
        for (int i = 0; i < LANE_W; i++) m[i] = (bank * LANE_W + i) < npins;
        return m;
    endfunction

endpackage

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    wr_en,
    input  logic [7:0]                              addr,
    input  logic [LANE_W-1:0]                       wdata,
    output logic [NUM_KINDS-2:0][NUM_PINS-1:0]      en
);

    for (genvar k = 1; k < NUM_KINDS; k++) begin : g_kind
        logic [NUM_PINS-1:0] en_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= '0;
            end else if (wr_en) begin
                for (int i = 0; i < NUM_PINS; i++) begin
                    if (addr == reg_addr(evt_kind_e'(k), i / LANE_W))
                        en_q[i] <= wdata[i % LANE_W];
                end
            end
        end

        assign en[k-1] = en_q;
    end

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NUM_PINS-1:0]                     pin_level,
    input  logic [NUM_PINS-1:0]                     pin_raw,
    input  logic [NUM_KINDS-2:0][NUM_PINS-1:0]      en,
    output logic [NUM_PINS-1:0]                     evt
);

    logic [NUM_PINS-1:0] lvl_prev;
    logic [NUM_PINS-1:0] raw_cap;
    logic [NUM_PINS-1:0] raw_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev <= '0;
            raw_cap  <= '0;
            raw_prev <= '0;
        end else begin
            lvl_prev <= pin_level;
            raw_cap  <= pin_raw;
            raw_prev <= raw_cap;
        end
    end

    // Enable index = kind - 1.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic s_rise, s_fall, r_rise, r_fall;
        assign s_rise = pin_level[i] & ~lvl_prev[i];
        assign s_fall = ~pin_level[i] & lvl_prev[i];
        assign r_rise = raw_cap[i] & ~raw_prev[i];
        assign r_fall = ~raw_cap[i] & raw_prev[i];
        assign evt[i] = (en[int'(K_RISE)  - 1][i] & s_rise)
                      | (en[int'(K_FALL)  - 1][i] & s_fall)
                      | (en[int'(K_HIGH)  - 1][i] & pin_level[i])
                      | (en[int'(K_LOW)   - 1][i] & ~pin_level[i])
                      | (en[int'(K_ARISE) - 1][i] & r_rise)
                      | (en[int'(K_AFALL) - 1][i] & r_fall);
    end

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
    parameter int NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] evt,
    input  logic [NUM_PINS-1:0] clr_mask,
    output logic [NUM_PINS-1:0] status
);

    // New capture dominates an acknowledge on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | evt;
    end

endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int NUM_BANKS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_level,
    input  logic [NUM_PINS-1:0]   pin_raw,
    output logic [NUM_BANKS-1:0]  irq_bank
);

    localparam int PAD_W = NUM_BANKS * LANE_W;

    logic [NUM_KINDS-2:0][NUM_PINS-1:0] en;
    logic [NUM_PINS-1:0]                evt;
    logic [NUM_PINS-1:0]                clr_mask;
    logic [NUM_PINS-1:0]                status_q;
    logic [NUM_KINDS-1:0][PAD_W-1:0]    view;

    gpio_evt_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .en    (en)
    );

    gpio_evt_detect #(.NUM_PINS(NUM_PINS)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_level (pin_level),
        .pin_raw   (pin_raw),
        .en        (en),
        .evt       (evt)
    );

    gpio_evt_status #(.NUM_PINS(NUM_PINS)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_mask (clr_mask),
        .status   (status_q)
    );

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            clr_mask[i] = bus_wr
                        && (bus_addr == reg_addr(K_STAT, i / LANE_W))
                        && bus_wdata[i % LANE_W];
        end
    end

    assign view[0] = PAD_W'(status_q);
    for (genvar k = 1; k < NUM_KINDS; k++) begin : g_view
        assign view[k] = PAD_W'(en[k-1]);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq
        assign irq_bank[b] = |view[0][b*LANE_W +: LANE_W];
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_KINDS; k++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bus_addr == reg_addr(evt_kind_e'(k), b))
                    bus_rdata = view[k][b*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int NUM_BANKS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [7:0]           bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_BANKS-1:0] irq_bank,
    input logic [NUM_PINS-1:0]  status,
    input logic [NUM_PINS-1:0]  ev
);

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((status & $past(ev)) == $past(ev)));  // R8

    AST_STICKY_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((status & $past(status)) == $past(status)));  // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h40)
            |=> ((status[LANE_W-1:0] & $past(bus_wdata & ~ev[LANE_W-1:0])) == '0));  // R7

    AST_IRQ_DROP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_bank[0]) |-> $past(bus_wr));  // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> (irq_bank == '0));  // R9

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h44) |-> ((bus_rdata & ~lane_mask(NUM_PINS, 1)) == '0));  // R10

endmodule

bind gpio_evt_top gpio_evt_chk #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_bank  (irq_bank),
    .status    (status_q),
    .ev        (evt)
);

// File: tb/sim_gpio_evt_top.sv
module sim_gpio_evt_top;

    localparam int CLK_PERIOD = 10;
    localparam int NPINS      = 54;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [7:0]       bus_addr = 8'h00;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NPINS-1:0] lvl = '0;
    logic [NPINS-1:0] raw = '0;
    logic [1:0]       irq_bank;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_evt_top #(.NUM_PINS(NPINS), .NUM_BANKS(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_level (lvl),
        .pin_raw   (raw),
        .irq_bank  (irq_bank)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int k = 0; k < 7; k++) begin
            for (int b = 0; b < 2; b++) begin
                rd(8'(8'h40 + 12*k + 4*b), d);
                check("R1 reset register", d, 32'h0);
            end
        end
        check("R1 reset irq", {30'd0, irq_bank}, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(8'h4C, 32'hFFFF_FFFF);
        rd(8'h4C, d); check("R10 bank0 enable readback", d, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, d); check("R10 bank1 upper bits zero", d, 32'h003F_FFFF);
        rd(8'h3C, d); check("R10 unmapped below", d, 32'h0);
        rd(8'h94, d); check("R10 unmapped above", d, 32'h0);
        wr(8'h4C, 32'h0);
        wr(8'h50, 32'h0);
        rd(8'h4C, d); check("R10 enable cleared", d, 32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        wr(8'h4C, 32'h1);
        lvl[0] = 1'b1; tick();
        rd(8'h40, d); check("R2 rising captured", d, 32'h1);
        check("R9 bank0 irq raised", {30'd0, irq_bank}, 32'h1);
        wr(8'h40, 32'h1);
        rd(8'h40, d); check("R7 edge stays cleared", d, 32'h0);
        lvl[0] = 1'b0; tick();
        rd(8'h40, d); check("R2 falling ignored", d, 32'h0);
        wr(8'h4C, 32'h0);
    endtask

    task automatic t_both();
        logic [31:0] d;
        wr(8'h50, 32'h8);
        wr(8'h5C, 32'h8);
        lvl[35] = 1'b1; tick();
        rd(8'h44, d); check("R3 both: rising on pin 35", d, 32'h8);
        check("R9 only bank1 irq", {30'd0, irq_bank}, 32'h2);
        wr(8'h44, 32'h8);
        lvl[35] = 1'b0; tick();
        rd(8'h44, d); check("R3 both: falling on pin 35", d, 32'h8);
        wr(8'h44, 32'h8);
        rd(8'h44, d); check("R3 cleared", d, 32'h0);
        wr(8'h50, 32'h0);
        wr(8'h5C, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        lvl[7] = 1'b1; tick();
        wr(8'h64, 32'h80);
        tick();
        rd(8'h40, d); check("R4 high level captured", d, 32'h80);
        wr(8'h40, 32'h80);
        rd(8'h40, d); check("R5 level re-asserts after clear", d, 32'h80);
        lvl[7] = 1'b0; tick();
        wr(8'h40, 32'h80);
        rd(8'h40, d); check("R5 clear holds once level gone", d, 32'h0);
        wr(8'h64, 32'h0);
        wr(8'h74, 32'h0020_0000);
        tick();
        rd(8'h44, d); check("R5 low level on pin 53", d, 32'h0020_0000);
        lvl[53] = 1'b1;
        wr(8'h44, 32'h0020_0000);
        rd(8'h44, d); check("R5 low clear after level high", d, 32'h0);
        wr(8'h74, 32'h0);
        lvl[53] = 1'b0;
    endtask

    task automatic t_async();
        logic [31:0] d;
        wr(8'h7C, 32'h400);
        raw[10] = 1'b1; tick();
        rd(8'h40, d); check("R6 raw rise not yet", d, 32'h0);
        tick();
        rd(8'h40, d); check("R6 raw rise one edge later", d, 32'h400);
        wr(8'h40, 32'h400);
        wr(8'h88, 32'h400);
        raw[10] = 1'b0; tick();
        rd(8'h40, d); check("R6 raw fall not yet", d, 32'h0);
        tick();
        rd(8'h40, d); check("R6 raw fall captured", d, 32'h400);
        wr(8'h40, 32'h400);
        wr(8'h7C, 32'h0);
        wr(8'h88, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(8'h4C, 32'h6);
        lvl[1] = 1'b1; lvl[2] = 1'b1; tick();
        rd(8'h40, d); check("R2 two pins captured", d, 32'h6);
        wr(8'h40, 32'h4);
        rd(8'h40, d); check("R7 zero bits untouched", d, 32'h2);
        check("R9 irq held by remaining bit", {30'd0, irq_bank}, 32'h1);
        wr(8'h40, 32'h2);
        rd(8'h40, d); check("R7 all cleared", d, 32'h0);
        check("R9 irq dropped", {30'd0, irq_bank}, 32'h0);
        wr(8'h4C, 32'h0);
        lvl[1] = 1'b0; lvl[2] = 1'b0;
    endtask

    task automatic t_setwins();
        logic [31:0] d;
        wr(8'h4C, 32'h0010_0000);
        lvl[20] = 1'b1; tick();
        lvl[20] = 1'b0; tick();
        lvl[20] = 1'b1;
        wr(8'h40, 32'h0010_0000);
        rd(8'h40, d); check("R8 set wins over clear", d, 32'h0010_0000);
        wr(8'h40, 32'h0010_0000);
        rd(8'h40, d); check("R8 later clear works", d, 32'h0);
        wr(8'h4C, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        for (int n = 0; n < 6; n++) begin
            lvl = ~lvl; raw = ~raw; tick();
        end
        tick();
        rd(8'h40, d); check("R11 bank0 untouched", d, 32'h0);
        rd(8'h44, d); check("R11 bank1 untouched", d, 32'h0);
        check("R11 no irq", {30'd0, irq_bank}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_readback();
        t_rise();
        t_both();
        t_level();
        t_async();
        t_w1c();
        t_setwins();
        t_disabled();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule